// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets a clocked host read and write a 262,144-word by 16-bit asynchronous static RAM. The host gives a single-cycle request with a read/write flag, an 18-bit word address, 16-bit write data and a 2-bit lane mask. The block replies through a `ready` / `rvalid` handshake. It drives the memory's five active-low controls: chip select, output enable, write strobe, and one strobe for each byte lane. It also decides, cycle by cycle, whether the controller or the memory owns the shared data bus. The bus is brought out as a separate output word, an input word and a drive-enable, which the pad ring combines into the bidirectional pins.

Every interval is a whole number of clock cycles. Each count is the matching nanosecond figure divided by the clock period, rounded up, with a minimum of one. The intervals are the output-float lead before the write strobe falls, the write pulse (the longer of the strobe width and the data setup), and the read access time.

A write marked as burst keeps the write strobe low after its pulse. The controller then offers a gap cycle in which the next word can be accepted. Each later word is framed only by the byte strobes, each with its own address setup cycle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During reset and whenever the block is idle, chip select, output enable, write strobe and both lane strobes are high, the bus drive-enable is low, `ready` is high and `rvalid` is low.
- R2: After a write is accepted from idle, chip select goes low with every other control high and the bus undriven for C_SET cycles. Then the write strobe and the selected lane strobes go low for C_PW cycles, with the address and write data on the bus.
- R3: A single write ends with the write strobe and lane strobes rising together. Chip select, address and data are then held, with the bus still driven, for one further cycle before the block returns to idle.
- R4: `bmask[1]` selects bits 15:8 through the upper strobe, and `bmask[0]` selects bits 7:0 through the lower strobe. A lane that is not selected keeps its strobe high and its memory contents unchanged. A mask of 00 writes nothing.
- R5: A read spends one turnaround cycle with chip select low, output enable high and the bus released. It then holds output enable low, together with the selected lane strobes, for C_ACC cycles.
- R6: In the cycle after the last access cycle, `rvalid` is high for one cycle only. `rdata` then carries the memory word, with every unselected lane forced to zero.
- R7: `ready` is low while an access is in progress. A request held during that time has no effect on the memory pins until `ready` returns high.
- R8: A write accepted with `burst` high leaves the write strobe low and enters a gap cycle: lane strobes high, old address and data held, `ready` high. A write accepted in the gap gets one cycle of new address and data with lane strobes high, then its own pulse. The write strobe stays low throughout.
- R9: From the gap, the burst ends in one of three ways. With no request, the block returns to idle in the next cycle. A write with `burst` low is the last word and ends as in R3. A read raises the write strobe and starts with its turnaround cycle.
- R10: The bus drive-enable is never high while output enable is low, and it is low in the cycle before output enable falls.
- R11: The write strobe and a lane strobe are low together only while chip select is low, output enable is high and the bus is driven. The memory then holds exactly the words that the accepted writes give.
- R12: C_SET, C_PW and C_ACC are computed from the timing parameters and the clock period by rounding up, with a minimum of 1. Every write pulse lasts at least C_PW cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, accepted on a rising edge while `ready` is high |
| wr | input | 1 | 1 = write, 0 = read |
| burst | input | 1 | For writes, keep the write strobe low after this word |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| bmask | input | 2 | Lane select, bit 1 upper, bit 0 lower |
| ready | output | 1 | Block can accept a request this cycle |
| rvalid | output | 1 | One-cycle read data strobe |
| rdata | output | DATA_W | Read data, unselected lanes zero |
| sram_addr | output | ADDR_W | Memory address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_ub_n | output | 1 | Upper lane strobe, active low |
| sram_lb_n | output | 1 | Lower lane strobe, active low |
| sram_dq_out | output | DATA_W | Data driven toward the memory |
| sram_dq_oe | output | 1 | Drive-enable for `sram_dq_out` |
| sram_dq_in | input | DATA_W | Data returned from the memory bus |

## Verification
Some pin rules are checked by assertions on every cycle. These are the bus-ownership rules, the write overlap occurring only with the bus driven and output enable high, the preparation before the write strobe falls, the hold after a terminating edge, the minimum pulse width, the single-cycle `rvalid` and the pin state while `ready` is high in a gap. Other behaviour can only be shown by the bench's scenarios. It compares every pin, every cycle, against a queue of expected states built from accepted requests. It runs a behavioural memory and checks it against a reference copy. This covers lane masking, stall behaviour, the three ways out of a burst, and multi-cycle counts derived from non-default timing values.

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl #(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 16,
  parameter int CLK_PS     = 20000,
  parameter int T_WP_PS    = 8000,
  parameter int T_SD_PS    = 6000,
  parameter int T_OEHZ_PS  = 4000,
  parameter int T_ACC_PS   = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic              burst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        bmask,
  output logic              ready,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic              sram_ub_n,
  output logic              sram_lb_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  function automatic int to_cyc(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int LANE_W = DATA_W / 2;
  localparam int C_SET  = to_cyc(T_OEHZ_PS);
  localparam int C_PW   = (to_cyc(T_WP_PS) > to_cyc(T_SD_PS)) ? to_cyc(T_WP_PS) : to_cyc(T_SD_PS);
  localparam int C_ACC  = to_cyc(T_ACC_PS);
  localparam int C_MAX  = (C_SET > C_PW) ? ((C_SET > C_ACC) ? C_SET : C_ACC)
                                         : ((C_PW > C_ACC) ? C_PW : C_ACC);
  localparam int CW     = $clog2(C_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WSET, S_WPUL, S_WHLD, S_BGAP, S_BSET, S_RTRN, S_RACC
  } st_t;

  st_t              st, st_n;
  logic [CW-1:0]    cnt, cnt_n;
  logic [1:0]       m_q, m_n;
  logic             burst_q;
  logic [5:0]       ctl_n;
  logic             last, accept, rd_done;

  assign last    = (cnt == '0);
  assign ready   = (st == S_IDLE) || (st == S_BGAP);
  assign accept  = req && ready;
  assign m_n     = accept ? bmask : m_q;
  assign rd_done = (st == S_RACC) && last;

  always_comb begin
    st_n  = st;
    cnt_n = last ? '0 : cnt - CW'(1);
    case (st)
      S_IDLE: if (req) begin
        st_n  = wr ? S_WSET : S_RTRN;
        cnt_n = CW'(C_SET - 1);
      end
      S_WSET: if (last) begin
        st_n  = S_WPUL;
        cnt_n = CW'(C_PW - 1);
      end
      S_BSET: begin
        st_n  = S_WPUL;
        cnt_n = CW'(C_PW - 1);
      end
      S_WPUL: if (last) st_n = burst_q ? S_BGAP : S_WHLD;
      S_WHLD: st_n = S_IDLE;
      S_BGAP: st_n = req ? (wr ? S_BSET : S_RTRN) : S_IDLE;
      S_RTRN: begin
        st_n  = S_RACC;
        cnt_n = CW'(C_ACC - 1);
      end
      S_RACC: if (last) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  // {ce_n, oe_n, we_n, ub_n, lb_n, dq_oe} for the state entered next
  always_comb begin
    case (st_n)
      S_WSET:          ctl_n = 6'b011110;
      S_WPUL:          ctl_n = {3'b010, ~m_n[1], ~m_n[0], 1'b1};
      S_WHLD:          ctl_n = 6'b011111;
      S_BGAP, S_BSET:  ctl_n = 6'b010111;
      S_RTRN:          ctl_n = 6'b011110;
      S_RACC:          ctl_n = {3'b001, ~m_n[1], ~m_n[0], 1'b0};
      default:         ctl_n = 6'b111110;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      m_q         <= '0;
      burst_q     <= 1'b0;
      sram_addr   <= '0;
      sram_dq_out <= '0;
      {sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n, sram_dq_oe} <= 6'b111110;
      rvalid      <= 1'b0;
      rdata       <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
      m_q <= m_n;
      if (accept) begin
        sram_addr <= addr;
        burst_q   <= burst && wr;
        if (wr) sram_dq_out <= wdata;
      end
      {sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n, sram_dq_oe} <= ctl_n;
      rvalid <= rd_done;
      if (rd_done)
        rdata <= sram_dq_in & {{LANE_W{m_q[1]}}, {LANE_W{m_q[0]}}};
    end
  end

  logic wr_ovl;
  logic [CW:0] pw_len;
  assign wr_ovl = !sram_we_n && !(sram_ub_n && sram_lb_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pw_len <= '0;
    else if (wr_ovl) pw_len <= pw_len + (CW+1)'(1);
    else             pw_len <= '0;
  end

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !sram_dq_oe); // R10
  AST_BUS_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_oe_n) |-> !$past(sram_dq_oe)); // R10
  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ovl |-> (!sram_ce_n && sram_oe_n && sram_dq_oe)); // R11
  AST_WE_PREP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> $past(sram_oe_n && !sram_ce_n && !sram_dq_oe)); // R2
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_ovl) && !wr_ovl) |-> (sram_dq_oe && !sram_ce_n && $stable(sram_addr) && $stable(sram_dq_out))); // R3
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ovl && pw_len != '0) |-> (pw_len >= (CW+1)'(C_PW))); // R12
  AST_RVALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid); // R6
  AST_GAP_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !sram_ce_n) |-> (!sram_we_n && sram_ub_n && sram_lb_n && sram_oe_n)); // R8

endmodule

// File: tb/sram_lane_ctrl_tb.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb;
  localparam int CLK_PS = 20000, T_WP = 30000, T_SD = 6000, T_OEHZ = 25000, T_ACC = 45000;

  function automatic int ceil_cyc(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  // R12: expected counts derived independently from the timing values
  localparam int S = ceil_cyc(T_OEHZ);
  localparam int P = (ceil_cyc(T_WP) > ceil_cyc(T_SD)) ? ceil_cyc(T_WP) : ceil_cyc(T_SD);
  localparam int A = ceil_cyc(T_ACC);

  logic clk = 0, rst_n = 0;
  logic req = 0, wr = 0, burst = 0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  bmask = '0;
  logic ready, rvalid;
  logic [15:0] rdata, dq_out, dq_bus;
  logic [17:0] s_addr;
  logic ce_n, oe_n, we_n, ub_n, lb_n, dq_oe;
  logic [15:0] sram_drive = '0;

  always #10 clk = ~clk;

  sram_lane_ctrl #(.CLK_PS(CLK_PS), .T_WP_PS(T_WP), .T_SD_PS(T_SD),
                   .T_OEHZ_PS(T_OEHZ), .T_ACC_PS(T_ACC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .burst(burst), .addr(addr),
    .wdata(wdata), .bmask(bmask), .ready(ready), .rvalid(rvalid), .rdata(rdata),
    .sram_addr(s_addr), .sram_ce_n(ce_n), .sram_oe_n(oe_n), .sram_we_n(we_n),
    .sram_ub_n(ub_n), .sram_lb_n(lb_n), .sram_dq_out(dq_out), .sram_dq_oe(dq_oe),
    .sram_dq_in(dq_bus));

  assign dq_bus = dq_oe ? dq_out : sram_drive;

  typedef struct {
    logic ce, oe, we, ub, lb, rdy, doe, rv, acare;
    logic [17:0] a;
    logic [15:0] d, rd;
    int rq;
  } exp_t;

  exp_t q[$];
  logic [15:0] sram_mem [int];
  logic [15:0] ref_mem  [int];
  int checks = 0, errors = 0, cycles = 0, scen_rq = 0;
  bit done = 0;

  function automatic logic [15:0] rd_word(input logic [15:0] mem [int], input int k);
    return mem.exists(k) ? mem[k] : 16'h0000;
  endfunction

  function automatic exp_t mk(input logic ce, oe, we, ub, lb, rdy, doe, input int rq);
    exp_t e;
    e.ce = ce; e.oe = oe; e.we = we; e.ub = ub; e.lb = lb; e.rdy = rdy; e.doe = doe;
    e.rv = 0; e.acare = 0; e.a = '0; e.d = '0; e.rd = '0;
    e.rq = (scen_rq != 0) ? scen_rq : rq;
    return e;
  endfunction

  task automatic chk(input bit ok, input int rq, input string what, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h at t=%0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic push_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] m,
                            input bit b, input bit from_gap);
    exp_t e;
    logic [15:0] w;
    if (!from_gap) begin
      for (int i = 0; i < S; i++) begin
        e = mk(0, 1, 1, 1, 1, 0, 0, 2); e.acare = 1; e.a = a; q.push_back(e);   // R2 setup
      end
    end else begin
      e = mk(0, 1, 0, 1, 1, 0, 1, 8); e.acare = 1; e.a = a; e.d = d; q.push_back(e); // R8 new word setup
    end
    for (int i = 0; i < P; i++) begin
      e = mk(0, 1, 0, !m[1], !m[0], 0, 1, from_gap ? 8 : 2);   // R4 lane strobes
      e.acare = 1; e.a = a; e.d = d; q.push_back(e);
    end
    if (b) e = mk(0, 1, 0, 1, 1, 1, 1, 8);   // R8 gap
    else   e = mk(0, 1, 1, 1, 1, 0, 1, 3);   // R3 hold
    e.acare = 1; e.a = a; e.d = d; q.push_back(e);
    if (m != 2'b00) begin
      w = rd_word(ref_mem, int'(a));
      if (m[1]) w[15:8] = d[15:8];
      if (m[0]) w[7:0]  = d[7:0];
      ref_mem[int'(a)] = w;
    end
  endtask

  task automatic push_read(input logic [17:0] a, input logic [1:0] m, input bit from_gap);
    exp_t e;
    logic [15:0] w;
    e = mk(0, 1, 1, 1, 1, 0, 0, from_gap ? 9 : 5); e.acare = 1; e.a = a; q.push_back(e); // R5 turnaround
    for (int i = 0; i < A; i++) begin
      e = mk(0, 0, 1, !m[1], !m[0], 0, 0, 5); e.acare = 1; e.a = a; q.push_back(e);
    end
    w = rd_word(ref_mem, int'(a));
    e = mk(1, 1, 1, 1, 1, 1, 0, 6);   // R6 valid pulse, unselected lanes zero
    e.rv = 1; e.rd = {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    exp_t e;
    logic [15:0] w;
    if (!rst_n) begin
      // R1: reset state of the pins and handshake
      chk({ce_n, oe_n, we_n, ub_n, lb_n} == 5'b11111, 1, "reset controls", {27'b0, ce_n, oe_n, we_n, ub_n, lb_n}, 32'h1f);
      chk(!dq_oe && ready && !rvalid, 1, "reset handshake", {29'b0, dq_oe, ready, rvalid}, 32'h2);
    end else if (!done) begin
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
      if (q.size() > 0) e = q.pop_front();
      else e = mk(1, 1, 1, 1, 1, 1, 0, 1);
      chk({ce_n, oe_n, we_n} == {e.ce, e.oe, e.we}, e.rq, "ce/oe/we", {29'b0, ce_n, oe_n, we_n}, {29'b0, e.ce, e.oe, e.we});
      chk({ub_n, lb_n} == {e.ub, e.lb}, (scen_rq != 0) ? e.rq : 4, "lane strobes", {30'b0, ub_n, lb_n}, {30'b0, e.ub, e.lb});
      chk(ready == e.rdy, (scen_rq != 0) ? e.rq : 7, "ready", {31'b0, ready}, {31'b0, e.rdy}); // R7
      chk(dq_oe == e.doe, (scen_rq != 0) ? e.rq : 10, "bus drive", {31'b0, dq_oe}, {31'b0, e.doe}); // R10
      chk(rvalid == e.rv, 6, "rvalid", {31'b0, rvalid}, {31'b0, e.rv});
      if (e.rv) chk(rdata == e.rd, e.rq, "rdata", {16'b0, rdata}, {16'b0, e.rd});
      if (e.acare) chk(s_addr == e.a, e.rq, "address", {14'b0, s_addr}, {14'b0, e.a});
      if (e.doe) chk(dq_out == e.d, e.rq, "write data", {16'b0, dq_out}, {16'b0, e.d});
      // behavioural memory: lanes written only in the three-signal overlap (R11)
      if (!ce_n && !we_n && !(ub_n && lb_n)) begin
        chk(dq_oe && oe_n, 11, "bus state during write", {30'b0, dq_oe, oe_n}, 32'h3);
        w = rd_word(sram_mem, int'(s_addr));
        if (!ub_n) w[15:8] = dq_bus[15:8];
        if (!lb_n) w[7:0]  = dq_bus[7:0];
        sram_mem[int'(s_addr)] = w;
      end
      sram_drive = '0;
      if (!ce_n && !oe_n && we_n) begin
        w = rd_word(sram_mem, int'(s_addr));
        if (!ub_n) sram_drive[15:8] = w[15:8];
        if (!lb_n) sram_drive[7:0]  = w[7:0];
      end
      if (req && e.rdy) begin
        if (wr) push_write(addr, wdata, bmask, burst, !e.ce);
        else    push_read(addr, bmask, !e.ce);
      end
    end
  end

  task automatic do_req(input bit w, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] m, input bit b);
    req = 1; wr = w; addr = a; wdata = d; bmask = m; burst = b;
    do @(negedge clk); while (!ready);
    @(posedge clk); #1;
    req = 0; burst = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (q.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) @(posedge clk); #1;

    // R2, R3, R5, R6: full word write and read back
    do_req(1, 18'h00010, 16'hA5C3, 2'b11, 0); wait_idle();
    do_req(0, 18'h00010, 16'h0000, 2'b11, 0); wait_idle();
    // R4: upper-only write, lower-only read, mask 00 write
    scen_rq = 4;
    do_req(1, 18'h00010, 16'h12FF, 2'b10, 0); wait_idle();
    do_req(0, 18'h00010, 16'h0, 2'b11, 0); wait_idle();
    do_req(0, 18'h00010, 16'h0, 2'b01, 0); wait_idle();
    do_req(1, 18'h00020, 16'hDEAD, 2'b00, 0); wait_idle();
    do_req(0, 18'h00020, 16'h0, 2'b11, 0); wait_idle();
    // R7: second request held while busy; R10: write then read back to back
    scen_rq = 7;
    do_req(1, 18'h00030, 16'h0F0F, 2'b11, 0);
    do_req(0, 18'h00030, 16'h0, 2'b11, 0);
    do_req(1, 18'h3FFFF, 16'h8001, 2'b11, 0);
    do_req(0, 18'h3FFFF, 16'h0, 2'b10, 0); wait_idle();
    // R8: burst of four words, last one closes the burst (R9)
    scen_rq = 8;
    do_req(1, 18'h00100, 16'h1111, 2'b11, 1);
    do_req(1, 18'h00101, 16'h2222, 2'b01, 1);
    do_req(1, 18'h00102, 16'h3333, 2'b10, 1);
    do_req(1, 18'h00103, 16'h4444, 2'b11, 0); wait_idle();
    // R9: burst ended by an empty gap, then by a read in the gap
    scen_rq = 9;
    do_req(1, 18'h00200, 16'h5A5A, 2'b11, 1); wait_idle();
    do_req(1, 18'h00201, 16'h6B6B, 2'b11, 1);
    do_req(0, 18'h00101, 16'h0, 2'b11, 0); wait_idle();
    scen_rq = 0;
    for (int k = 0; k < 4; k++) begin
      do_req(0, 18'h00100 + 18'(k), 16'h0, 2'b11, 0); wait_idle();
    end
    do_req(0, 18'h00200, 16'h0, 2'b11, 0); wait_idle();
    repeat (3) @(posedge clk);

    // R11: behavioural memory matches the reference copy exactly
    done = 1;
    foreach (ref_mem[k]) chk(rd_word(sram_mem, k) == ref_mem[k], 11, "memory word", {16'b0, rd_word(sram_mem, k)}, {16'b0, ref_mem[k]});
    foreach (sram_mem[k]) chk(ref_mem.exists(k), 11, "unexpected word written", k, 32'hffffffff);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule